// File: doc/BRIEF.md
# Bracket-Matching Loop Scan Controller

This block finds the partner of a loop bracket in a Brainfuck-style program held in instruction memory. It contains the decimal instruction pointer. When the sequencer decides that a jump is needed at an opening or closing bracket, it raises a start request and gives the scan direction. The controller then walks the pointer one instruction at a time, forward or backward. An internal, clearable nesting counter records how many inner loops have been entered and left along the way.

On every step the opcode at the pointer is reported back by an external decoder as open bracket, close bracket or other. The scan stops on the first closing-kind bracket (for the scan direction) that arrives while the nesting count is zero. The pointer is left on that bracket and a one-cycle done pulse is raised. Outside a scan, the pointer can be stepped by one or cleared, so normal sequential fetch uses the same counter.

Top module: `bscan_ctrl`

## Requirements
- R1: After synchronous reset the pointer reads 0, and busy, done and both step strobes are low.
- R2: The pointer is a binary-coded-decimal counter of DIGITS digits, with digit i in bits [4i+3:4i]. An external up step adds one with decimal carry. An external down step subtracts one with decimal borrow. 0 minus one gives all nines, and all nines plus one gives 0. Up and down requested together cause no move.
- R3: ptr_clr sets the pointer to 0 on the next edge and takes priority over every step.
- R4: External step requests are ignored while busy, and in the cycle in which a start is taken.
- R5: A forward scan (scan_back=0, started on an open bracket) ends on the close bracket that matches it, skipping nested pairs. Opcode encoding: 2'b01 open, 2'b10 close, 2'b00 and 2'b11 other.
- R6: A backward scan (scan_back=1, started on a close bracket) ends on the open bracket that matches it, skipping nested pairs.
- R7: For a match k instructions away, busy is high for 2k+1 cycles after the start edge: two cycles per step and one done cycle. done is high for exactly one cycle, and only while busy.
- R8: A start request arriving while busy is ignored, whatever its direction.
- R9: Every pointer move pulses exactly one strobe: step_up on increments, step_dn on decrements. A scan of distance k produces k strobes of its own direction only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_clr | input | 1 | Synchronous pointer clear |
| ext_up | input | 1 | Step pointer up by one when idle |
| ext_dn | input | 1 | Step pointer down by one when idle |
| scan_start | input | 1 | Begin a bracket scan |
| scan_back | input | 1 | Scan direction, 1 = backward |
| opcode | input | 2 | Decoded opcode class at the pointer |
| addr | output | 4*DIGITS | Pointer value, BCD |
| step_up | output | 1 | Pointer increments this cycle |
| step_dn | output | 1 | Pointer decrements this cycle |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle scan completion pulse |

## Verification
The embedded properties watch, on every cycle, that each pointer digit stays in 0..9, that a clear empties the pointer, that the strobes are never both high, that external steps cannot leak through during a scan, and that done is a single-cycle pulse inside busy. Whether the scan lands on the correct partner bracket, and its exact cycle count, depend on program content. Only the bench's sweep shows these: it starts a scan from every bracket of a small program with nested and adjacent pairs and compares against a reference walk, while injecting a stray start and a stray step mid-scan.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        OPC_OTHER = 2'b00,
        OPC_OPEN  = 2'b01,
        OPC_CLOSE = 2'b10,
        OPC_SPARE = 2'b11
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_EVAL,
        ST_DONE
    } scan_st_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    function automatic logic [3:0] digit_up(input logic [3:0] d);
        return (d == 4'd9) ? 4'd0 : d + 4'd1;
    endfunction

    function automatic logic [3:0] digit_dn(input logic [3:0] d);
        return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

endpackage

// File: rtl/bcd_ptr.sv
module bcd_ptr
    import bscan_pkg::*;
#(
    parameter int DIGITS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  step_t                 step,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS:0] carry_up;
    logic [DIGITS:0] borrow_dn;

    assign carry_up[0]  = step.up && !step.dn;
    assign borrow_dn[0] = step.dn && !step.up;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] dig;

        always_ff @(posedge clk) begin
            if (rst || clr)
                dig <= 4'd0;
            else if (carry_up[i])
                dig <= digit_up(dig);
            else if (borrow_dn[i])
                dig <= digit_dn(dig);
        end

        assign carry_up[i+1]  = carry_up[i]  && (dig == 4'd9);
        assign borrow_dn[i+1] = borrow_dn[i] && (dig == 4'd0);
        assign value[4*i +: 4] = dig;

        // R2
        digit_range_chk: assert property (@(posedge clk) disable iff (rst)
            dig <= 4'd9);
    end

endmodule

// File: rtl/depth_ctr.sv
module depth_ctr #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic zero
);
    logic [WIDTH-1:0] level;

    always_ff @(posedge clk) begin
        if (rst || clr)
            level <= '0;
        else if (inc && !dec)
            level <= level + 1'b1;
        else if (dec && !inc)
            level <= level - 1'b1;
    end

    assign zero = (level == '0);

    // R5
    depth_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> zero);

endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
    import bscan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  back,
    input  opc_e  opc,
    input  logic  depth_zero,
    output step_t step,
    output logic  depth_clr,
    output logic  depth_inc,
    output logic  depth_dec,
    output logic  busy,
    output logic  done
);
    scan_st_e state;
    logic     back_q;
    logic     hit;
    logic     nest;
    logic     finish;
    logic     move;
    logic     dir_back;

    assign hit    = back_q ? (opc == OPC_OPEN)  : (opc == OPC_CLOSE);
    assign nest   = back_q ? (opc == OPC_CLOSE) : (opc == OPC_OPEN);
    assign finish = (state == ST_EVAL) && hit && depth_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            back_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    back_q <= back;
                    state  <= ST_SETTLE;
                end
                ST_SETTLE: state <= ST_EVAL;
                ST_EVAL:   state <= finish ? ST_DONE : ST_SETTLE;
                ST_DONE:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        move     = ((state == ST_IDLE) && start) || ((state == ST_EVAL) && !finish);
        dir_back = (state == ST_IDLE) ? back : back_q;
        step.up  = move && !dir_back;
        step.dn  = move && dir_back;
    end

    assign depth_clr = (state == ST_IDLE) && start;
    assign depth_inc = (state == ST_EVAL) && nest;
    assign depth_dec = (state == ST_EVAL) && hit && !depth_zero;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

    // R7
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
    import bscan_pkg::*;
#(
    parameter int DIGITS  = 6,
    parameter int DEPTH_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ptr_clr,
    input  logic                ext_up,
    input  logic                ext_dn,
    input  logic                scan_start,
    input  logic                scan_back,
    input  logic [1:0]          opcode,
    output logic [4*DIGITS-1:0] addr,
    output logic                step_up,
    output logic                step_dn,
    output logic                busy,
    output logic                done
);
    localparam int ADDR_W = 4 * DIGITS;

    step_t fsm_step;
    step_t ptr_step;
    logic  ext_ok;
    logic  d_clr, d_inc, d_dec, d_zero;

    scan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (scan_start),
        .back       (scan_back),
        .opc        (opc_e'(opcode)),
        .depth_zero (d_zero),
        .step       (fsm_step),
        .depth_clr  (d_clr),
        .depth_inc  (d_inc),
        .depth_dec  (d_dec),
        .busy       (busy),
        .done       (done)
    );

    depth_ctr #(.WIDTH(DEPTH_W)) u_depth (
        .clk  (clk),
        .rst  (rst),
        .clr  (d_clr),
        .inc  (d_inc),
        .dec  (d_dec),
        .zero (d_zero)
    );

    assign ext_ok      = !busy && !scan_start && (ext_up ^ ext_dn);
    assign ptr_step.up = !ptr_clr && (fsm_step.up || (ext_ok && ext_up));
    assign ptr_step.dn = !ptr_clr && (fsm_step.dn || (ext_ok && ext_dn));

    bcd_ptr #(.DIGITS(DIGITS)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .clr   (ptr_clr),
        .step  (ptr_step),
        .value (addr)
    );

    assign step_up = ptr_step.up;
    assign step_dn = ptr_step.dn;

    // R3
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_clr |=> (addr == {ADDR_W{1'b0}}));
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_dn}));
    // R4
    ext_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fsm_step.up && !fsm_step.dn) |-> !(step_up || step_dn));
    // R9
    still_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_up && !step_dn && !ptr_clr) |=> $stable(addr));

endmodule

// File: tb/bscan_ctrl_tb_top.sv
module bscan_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIGITS     = 6;
    localparam int PROG_LEN   = 200;

    logic                clk = 1'b0;
    logic                rst, ptr_clr, ext_up, ext_dn, scan_start, scan_back;
    logic [1:0]          opcode;
    logic [4*DIGITS-1:0] addr;
    logic                step_up, step_dn, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [1:0] prog [PROG_LEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    bscan_ctrl #(.DIGITS(DIGITS)) dut_i (
        .clk(clk), .rst(rst), .ptr_clr(ptr_clr), .ext_up(ext_up), .ext_dn(ext_dn),
        .scan_start(scan_start), .scan_back(scan_back), .opcode(opcode),
        .addr(addr), .step_up(step_up), .step_dn(step_dn), .busy(busy), .done(done)
    );

    function automatic int bcd2int(input logic [4*DIGITS-1:0] v);
        int r = 0;
        for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [4*DIGITS-1:0] int2bcd(input int n);
        logic [4*DIGITS-1:0] r = '0;
        int m = n;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(m % 10);
            m = m / 10;
        end
        return r;
    endfunction

    always_comb begin
        int a;
        a = bcd2int(addr);
        opcode = (a < PROG_LEN) ? prog[a] : 2'b00;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic goto(input int n);
        ptr_clr = 1'b1;
        tick();
        ptr_clr = 1'b0;
        ext_up  = 1'b1;
        for (int i = 0; i < n; i++) tick();
        ext_up = 1'b0;
        check("R2 positioned pointer", bcd2int(addr), n);
    endtask

    function automatic int ref_match(input int origin, input logic back);
        int i = origin;
        int d = 0;
        for (int s = 0; s < PROG_LEN; s++) begin
            i = back ? i - 1 : i + 1;
            if (prog[i] == (back ? 2'b01 : 2'b10)) begin
                if (d == 0) return i;
                d--;
            end else if (prog[i] == (back ? 2'b10 : 2'b01)) begin
                d++;
            end
        end
        return -1;
    endfunction

    task automatic run_scan(input int origin, input logic back);
        int exp_pos = ref_match(origin, back);
        int k = back ? origin - exp_pos : exp_pos - origin;
        int nb = 0, nd = 0, nu = 0, ndn = 0, stray = 0;
        bit fin = 0;
        goto(origin);
        scan_back  = back;
        scan_start = 1'b1;
        for (int cyc = 0; cyc < 1000 && !fin; cyc++) begin
            @(negedge clk);
            if (step_up) nu++;
            if (step_dn) ndn++;
            if (busy) nb++;
            if (done) nd++;
            if (done && !busy) stray++;
            if (cyc > 0 && !busy) fin = 1;
            @(posedge clk);
            #1;
            // R4 and R8: disturbance during the scan
            scan_start = (cyc == 2);
            scan_back  = (cyc == 2) ? !back : back;
            ext_up     = (cyc == 2);
        end
        scan_start = 1'b0;
        ext_up     = 1'b0;
        check(back ? "R6 backward match" : "R5 forward match", bcd2int(addr), exp_pos);
        check("R7 busy length", nb, 2 * k + 1);
        check("R7 done pulse count", nd, 1);
        check("R7 done outside busy", stray, 0);
        check("R9 strobes in scan direction", back ? ndn : nu, k);
        check("R9 strobes against direction", back ? nu : ndn, 0);
    endtask

    initial begin
        for (int i = 0; i < PROG_LEN; i++) prog[i] = (i % 3 == 0) ? 2'b11 : 2'b00;
        prog[5]  = 2'b01; prog[6]  = 2'b10;
        prog[10] = 2'b01; prog[11] = 2'b01; prog[12] = 2'b01;
        prog[13] = 2'b10; prog[14] = 2'b10; prog[15] = 2'b10;
        prog[95] = 2'b01; prog[96] = 2'b01; prog[98] = 2'b10;
        prog[99] = 2'b01; prog[100] = 2'b10; prog[103] = 2'b10;

        rst = 1'b1; ptr_clr = 1'b0; ext_up = 1'b0; ext_dn = 1'b0;
        scan_start = 1'b0; scan_back = 1'b0;
        tick(); tick();
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 reset pointer", bcd2int(addr), 0);
        check("R1 reset flags", {busy, done, step_up, step_dn}, 0);
        tick();

        // R2 wrap both ways
        ext_dn = 1'b1; tick(); ext_dn = 1'b0;
        check("R2 wrap below zero", int'(addr == int2bcd(999999)), 1);
        ext_up = 1'b1; tick(); ext_up = 1'b0;
        check("R2 wrap above max", bcd2int(addr), 0);
        ext_up = 1'b1; ext_dn = 1'b1; tick(); ext_up = 1'b0; ext_dn = 1'b0;
        check("R2 opposing steps cancel", bcd2int(addr), 0);

        // R3 clear beats a step
        goto(7);
        ptr_clr = 1'b1; ext_up = 1'b1; tick(); ptr_clr = 1'b0; ext_up = 1'b0;
        check("R3 clear priority", bcd2int(addr), 0);

        // R4 step in same cycle as start is dropped
        goto(99);
        scan_start = 1'b1; scan_back = 1'b0; ext_dn = 1'b1;
        @(negedge clk);
        check("R4 step with start", {step_up, step_dn}, 2'b10);
        tick(); scan_start = 1'b0; ext_dn = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        check("R4 scan after step drop", bcd2int(addr), 100);

        // R5 R6 sweep over every bracket
        for (int a = 0; a < PROG_LEN; a++) begin
            if (prog[a] == 2'b01) run_scan(a, 1'b0);
            else if (prog[a] == 2'b10) run_scan(a, 1'b1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule